// File: doc/BRIEF.md
# Dual-Channel Down-Counting Timer

This block is a register-mapped timer with two independent channels that count down. Each channel holds a 64-bit reload interval, split into a low and a high 32-bit word, and a 64-bit live counter that software can read as two words. A channel runs in one of two modes. In periodic mode it reloads the interval each time it reaches zero and keeps running. In one-shot mode it stops after it reaches zero once. A 3-bit prescaler select on each channel slows its counting by a power of two. A channel programmed with an all-ones interval in periodic mode works as a free-running counter. Software reads a rising timestamp from it by inverting the low count word.

Every expiry sets a sticky pending bit in a shared status register. Software clears a pending bit by writing 1 to it. A shared enable mask selects which pending bits drive the single interrupt line. When software clears a channel's run bit, the channel keeps counting for a short, fixed drain window before it really halts. Software has to allow for this window before it reprograms the channel.

The register port is a plain 32-bit port with one-cycle strobes. A write takes effect at the clock edge where its strobe is high. A read returns, one cycle later, the value the register held at the edge where its strobe was high.

Top module: `dual_down_timer`

## Requirements
- R1: After reset the interrupt-mask register, the pending register and every channel control, interval and count word read 0, and `irq` is low.
- R2: Address map. The mask is at 0x00, with bit n for channel n. The pending register is at 0x04. Channel n sits at base 0x20*n+0x10: control at +0x00, interval low at +0x04, interval high at +0x08, count low at +0x0C and count high at +0x10. Control fields are: bit 0 run, bit 1 load strobe (always reads 0), bits 6:4 prescaler select p, and bit 7 one-shot (1) or periodic (0). Interval and mask words read back as they were written.
- R3: A control write with both run and load set copies the interval into the counter at that edge. A count read issued in the next cycle returns the interval. Each following count tick lowers the counter by 1.
- R4: With prescaler select p, the counter ticks once every 2^p clocks. From the starting write edge, the first expiry comes (interval+1)*2^p clocks later.
- R5: In periodic mode the counter reloads the interval on expiry, so expiries repeat every (interval+1)*2^p clocks.
- R6: In one-shot mode an expiry clears the run bit, and no further expiry follows.
- R7: An expiry sets the channel's pending bit whatever the mask holds. `irq` is high exactly when some pending bit and its mask bit are both 1.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear of that bit leaves the bit set.
- R9: After a control write clears run, the counter keeps stepping for exactly 2 more clocks at p=0 and then holds its value.
- R10: Writes to the count words have no effect on the counter.
- R11: A periodic channel with an all-ones low interval, read on two consecutive cycles at p=0, gives inverted low count words that differ by exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timer source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Masked OR of the pending bits |

## Verification
Suppose the counter starts wrong, or a prescaler tick drifts by one clock. The interrupt then rises a cycle early or late. The bench measures the time to the interrupt against (interval+1)*2^p to the exact cycle, so this shows up at the first expiry. A channel that keeps counting after it is halted, or a count word that accepts writes, shows up as a mismatch in a count read a few cycles later. A lost or wrongly cleared pending bit shows up at once on `irq`, and on the next read of the pending register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 2 * WORD_W;
    localparam int PSEL_W    = 3;
    localparam int DIV_W     = (1 << PSEL_W) - 1;
    localparam int REG_IE    = 'h00;
    localparam int REG_ST    = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h20;
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_IV_LO = 'h04;
    localparam int OFF_IV_HI = 'h08;
    localparam int OFF_CN_LO = 'h0C;
    localparam int OFF_CN_HI = 'h10;

    typedef struct packed {
        logic              run;
        logic              one_shot;
        logic [PSEL_W-1:0] psel;
    } ch_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = ~({DIV_W{1'b1}} << psel);
        tick  = run && ((div_q & mask) == mask);
        div_d = div_q;
        if (clr)
            div_d = '0;
        else if (run)
            div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else
            div_q <= div_d;
    end

    // R4: with a divisor above one, ticks never fall on back-to-back clocks
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psel != '0 && !clr) |=> (!tick || psel != $past(psel)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int STOP_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              wr_run,
    input  logic              wr_load,
    input  logic              wr_one_shot,
    input  logic [PSEL_W-1:0] wr_psel,
    input  logic              iv_lo_we,
    input  logic              iv_hi_we,
    input  logic [WORD_W-1:0] wdata,
    output ch_ctrl_t          ctrl,
    output logic [CNT_W-1:0]  interval,
    output logic [CNT_W-1:0]  count,
    output logic              expire
);
    localparam int DRN_W = $clog2(STOP_LAT + 1);

    typedef struct packed {
        ch_ctrl_t         ctrl;
        logic [CNT_W-1:0] iv;
        logic [CNT_W-1:0] cnt;
        logic [DRN_W-1:0] drain;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      start, active, tick;

    tmr_prescaler u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active),
        .clr  (start),
        .psel (s_q.ctrl.psel),
        .tick (tick)
    );

    always_comb begin
        s_d    = s_q;
        start  = ctrl_we && wr_run && wr_load;
        active = s_q.ctrl.run || (s_q.drain != '0);
        expire = active && tick && (s_q.cnt == '0) && !start;

        if (s_q.drain != '0)
            s_d.drain = s_q.drain - 1'b1;

        if (active && tick) begin
            if (s_q.cnt == '0) begin
                if (s_q.ctrl.one_shot) begin
                    s_d.ctrl.run = 1'b0;
                    s_d.drain    = '0;
                end else begin
                    s_d.cnt = s_q.iv;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        if (ctrl_we) begin
            s_d.ctrl.run      = wr_run;
            s_d.ctrl.one_shot = wr_one_shot;
            s_d.ctrl.psel     = wr_psel;
            if (s_q.ctrl.run && !wr_run)
                s_d.drain = DRN_W'(STOP_LAT);
            if (start) begin
                s_d.cnt   = s_q.iv;
                s_d.drain = '0;
            end
        end

        if (iv_lo_we)
            s_d.iv[WORD_W-1:0] = wdata;
        if (iv_hi_we)
            s_d.iv[CNT_W-1:WORD_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign ctrl     = s_q.ctrl;
    assign interval = s_q.iv;
    assign count    = s_q.cnt;

    // R9: a halted channel whose drain window has run out keeps its count
    a_r9_halted_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.run && s_q.drain == '0 && !ctrl_we) |=> $stable(s_q.cnt));
    // R6: a one-shot expiry drops the run bit
    a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && s_q.ctrl.one_shot && !ctrl_we) |=> !s_q.ctrl.run);
    // R5: a periodic expiry reloads the interval
    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !s_q.ctrl.one_shot && !ctrl_we && !iv_lo_we && !iv_hi_we)
        |=> (s_q.cnt == $past(s_q.iv)));
    // R3: a start copies the interval into the counter
    a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !iv_lo_we && !iv_hi_we) |=> (s_q.cnt == $past(s_q.iv) && s_q.ctrl.run));
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import tmr_pkg::*;
#(
    parameter int N_CH     = 2,
    parameter int ADDR_W   = 8,
    parameter int STOP_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    typedef struct packed {
        logic [N_CH-1:0] ie;
        logic [N_CH-1:0] st;
        logic [31:0]     rdata;
    } top_state_t;

    top_state_t t_d, t_q;

    logic [N_CH-1:0] ctrl_we, lo_we, hi_we, exp_w;
    ch_ctrl_t        ctrl_w [N_CH];
    logic [CNT_W-1:0] iv_w  [N_CH];
    logic [CNT_W-1:0] cnt_w [N_CH];

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * i;

        assign ctrl_we[i] = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_CTRL));
        assign lo_we[i]   = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_IV_LO));
        assign hi_we[i]   = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_IV_HI));

        tmr_channel #(.STOP_LAT(STOP_LAT)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (ctrl_we[i]),
            .wr_run     (bus_wdata[0]),
            .wr_load    (bus_wdata[1]),
            .wr_one_shot(bus_wdata[7]),
            .wr_psel    (bus_wdata[6:4]),
            .iv_lo_we   (lo_we[i]),
            .iv_hi_we   (hi_we[i]),
            .wdata      (bus_wdata),
            .ctrl       (ctrl_w[i]),
            .interval   (iv_w[i]),
            .count      (cnt_w[i]),
            .expire     (exp_w[i])
        );

        // R7: a pending bit only rises after its channel expired
        a_r7_pending_source: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(t_q.st[i]) |-> $past(exp_w[i]));
    end

    always_comb begin
        t_d = t_q;
        if (bus_wr && bus_addr == ADDR_W'(REG_IE))
            t_d.ie = bus_wdata[N_CH-1:0];
        if (bus_wr && bus_addr == ADDR_W'(REG_ST))
            t_d.st = t_q.st & ~bus_wdata[N_CH-1:0];
        t_d.st = t_d.st | exp_w;

        if (bus_rd) begin
            t_d.rdata = '0;
            if (bus_addr == ADDR_W'(REG_IE))
                t_d.rdata[N_CH-1:0] = t_q.ie;
            if (bus_addr == ADDR_W'(REG_ST))
                t_d.rdata[N_CH-1:0] = t_q.st;
            for (int i = 0; i < N_CH; i++) begin
                if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + OFF_CTRL))
                    t_d.rdata = {24'd0, ctrl_w[i].one_shot, ctrl_w[i].psel, 3'd0, ctrl_w[i].run};
                if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + OFF_IV_LO))
                    t_d.rdata = iv_w[i][WORD_W-1:0];
                if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + OFF_IV_HI))
                    t_d.rdata = iv_w[i][CNT_W-1:WORD_W];
                if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + OFF_CN_LO))
                    t_d.rdata = cnt_w[i][WORD_W-1:0];
                if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + OFF_CN_HI))
                    t_d.rdata = cnt_w[i][CNT_W-1:WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            t_q <= '0;
        else
            t_q <= t_d;
    end

    assign bus_rdata = t_q.rdata;
    assign irq       = |(t_q.st & t_q.ie);

    // R8: an expiry beats a clear of the same bit
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|exp_w) |=> ((t_q.st & $past(exp_w)) == $past(exp_w)));
endmodule

// File: tb/dual_down_timer_bench.sv
module dual_down_timer_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          cyc = 0;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    dual_down_timer u_dual_down_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] a_ctrl(int ch);   return 8'(32*ch + 'h10); endfunction
    function automatic logic [7:0] a_ivlo(int ch);   return 8'(32*ch + 'h14); endfunction
    function automatic logic [7:0] a_ivhi(int ch);   return 8'(32*ch + 'h18); endfunction
    function automatic logic [7:0] a_cnlo(int ch);   return 8'(32*ch + 'h1C); endfunction
    function automatic logic [7:0] a_cnhi(int ch);   return 8'(32*ch + 'h20); endfunction
    function automatic int exp_cycles(int iv, int p); return (iv + 1) << p; endfunction
    function automatic logic [31:0] cword(bit run, bit load, int p, bit os);
        return {24'd0, os, 3'(p), 2'd0, load, run};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_to(int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int t0, td, e;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        rd(8'h00, v); check("R1 mask", v, 0);
        rd(8'h04, v); check("R1 pending", v, 0);
        for (int c = 0; c < 2; c++) begin
            rd(a_ctrl(c), v); check("R1 ctrl", v, 0);
            rd(a_cnlo(c), v); check("R1 count", v, 0);
            rd(a_ivhi(c), v); check("R1 interval", v, 0);
        end

        // R2 readback and field layout
        wr(a_ivhi(1), 32'hA5A5_0001); rd(a_ivhi(1), v); check("R2 interval hi", v, 32'hA5A5_0001);
        wr(a_ivhi(1), 32'h0);
        wr(8'h00, 32'h3); rd(8'h00, v); check("R2 mask", v, 32'h3);
        wr(a_ctrl(0), cword(0, 1, 5, 1)); rd(a_ctrl(0), v); check("R2 ctrl fields", v, 32'hD0);
        wr(a_ctrl(0), 0);

        // R3 start and count
        wr(a_ivlo(0), 32'd500); wr(a_ivhi(0), 0);
        wr(a_ctrl(0), cword(1, 1, 0, 0)); t0 = cyc;
        rd(a_cnlo(0), v); check("R3 load", v, 32'd500);
        rd(a_cnlo(0), v); check("R3 step", v, 32'd499);
        rd(a_cnhi(0), v); check("R3 high word", v, 0);

        // R9 drain after stop, R10 count write ignored
        wr(a_ctrl(0), 0); td = cyc;
        repeat (5) @(negedge clk);
        rd(a_cnlo(0), v); check("R9 halted value", v, 32'(500 - (td - t0) - 2));
        repeat (3) @(negedge clk);
        rd(a_cnlo(0), v2); check("R9 holds", v2, v);
        wr(a_cnlo(0), 32'h1234_5678);
        rd(a_cnlo(0), v2); check("R10 count write ignored", v2, v);
        wr(a_cnhi(0), 32'hFFFF_FFFF);
        rd(a_cnhi(0), v2); check("R10 count hi ignored", v2, 0);

        // R4 R5 R6 R7 random timing runs
        for (int it = 0; it < 10; it++) begin
            int ch, iv, p;
            bit os;
            ch = int'($urandom % 2); iv = 3 + int'($urandom % 10);
            p = int'($urandom % 3); os = 1'($urandom % 2);
            wr(a_ctrl(0), 0); wr(a_ctrl(1), 0);
            repeat (4) @(negedge clk);
            wr(8'h04, 32'h3); wr(8'h00, 32'(1 << ch));
            wr(a_ivlo(ch), 32'(iv)); wr(a_ivhi(ch), 0);
            wr(a_ctrl(ch), cword(1, 1, p, os)); t0 = cyc;
            e = exp_cycles(iv, p);
            wait_to(t0 + e - 1); check("R4 no early expiry", 32'(irq), 0);
            wait_to(t0 + e);     check("R4 expiry time", 32'(irq), 1);
            wr(8'h04, 32'(1 << ch)); check("R8 clear", 32'(irq), 0);
            if (!os) begin
                wait_to(t0 + 2*e - 1); check("R5 no early reload expiry", 32'(irq), 0);
                wait_to(t0 + 2*e);     check("R5 second expiry", 32'(irq), 1);
            end else begin
                wait_to(t0 + 3*e); check("R6 no second expiry", 32'(irq), 0);
                rd(a_ctrl(ch), v); check("R6 run cleared", v & 32'h1, 0);
            end
        end

        // R7 masked expiry still pends
        wr(a_ctrl(0), 0); wr(a_ctrl(1), 0);
        repeat (4) @(negedge clk);
        wr(8'h04, 32'h3); wr(8'h00, 0);
        wr(a_ivlo(1), 32'd3); wr(a_ctrl(1), cword(1, 1, 1, 1));
        repeat (12) @(negedge clk);
        check("R7 masked irq low", 32'(irq), 0);
        rd(8'h04, v); check("R7 pending set", v, 32'h2);
        wr(8'h00, 32'h2); check("R7 unmask raises irq", 32'(irq), 1);

        // R8 write 0 keeps, set beats clear
        wr(8'h04, 32'h0); rd(8'h04, v); check("R8 zero write keeps", v, 32'h2);
        wr(8'h04, 32'h2);
        wr(8'h00, 32'h1); wr(a_ivlo(0), 32'd3);
        wr(a_ctrl(0), cword(1, 1, 0, 1)); t0 = cyc;
        wait_to(t0 + 3);
        wr(8'h04, 32'h1);
        rd(8'h04, v); check("R8 set wins", v, 32'h1);

        // R11 free-running timestamp
        wr(a_ivlo(1), 32'hFFFF_FFFF); wr(a_ivhi(1), 0);
        wr(a_ctrl(1), cword(1, 1, 0, 0));
        repeat (7) @(negedge clk);
        rd(a_cnlo(1), v); rd(a_cnlo(1), v2);
        check("R11 rising stamp", (~v2) - (~v), 32'd1);

        finish_run();
    end
endmodule